// File: doc/BRIEF.md
# SMBus Transfer FIFO with Thresholds

This block sits between the software data register of an SMBus byte controller and that controller's shift engine. It holds up to 16 bytes waiting to be transmitted and up to 16 bytes already received. Software reaches it through a small register window that is shared with the controller's main registers. A bank-select input, driven by the controller's own control register, picks which bank the window addresses.

Software fills the transmit queue by writing the data register. The shift engine drains it one byte at a time. Bytes received by the shift engine go into the receive queue, and software collects them by reading the data register.

Each direction has a programmable threshold with a sticky "threshold reached" flag and an interrupt enable. A shared empty/full flag reports that the transmit queue has drained or that the receive queue is full. A data-ready output tells the controller whether received data may be handed to software. A small receive sequencer counts incoming bytes once a last-transfer marker is armed, and requests a NACK for the final byte of the programmed count.

The sequencer has four states, all of type `sq_state_t`:
- `SQ_IDLE`: no count is armed.
- `SQ_COUNT`: counting bytes, and more than one byte remains.
- `SQ_FINAL`: exactly one byte remains, and NACK is requested.
- `SQ_DONE`: the programmed count is complete.

Its transitions are as follows:
- A receive-control write with the marker set and a non-zero count moves to `SQ_FINAL` when the count is 1, and to `SQ_COUNT` otherwise.
- A receive-control write with the marker clear, or with a zero count, moves to `SQ_IDLE`.
- In `SQ_COUNT`, the byte that leaves one byte outstanding moves to `SQ_FINAL`.
- In `SQ_FINAL`, the next byte moves to `SQ_DONE`.
- A queue clear returns any state to `SQ_IDLE`.

Top module: `smb_xfer_fifo`

## Requirements
- R1: After reset, every register in both banks reads 0, and `irq`, `data_rdy`, `sh_nack` and `sh_tx_avail` are all 0.
- R2: With `bank_sel`=0, offset 0 holds the queue-enable bit at bit 4. With `bank_sel`=1, the same offset reaches the control-status register instead. A write in one bank leaves the other bank's register unchanged.
- R3: Bytes leave the transmit queue on `sh_tx_byte`, and the receive queue on `dat_rdata`, in the order they entered. Transmit-status (bank 1, offset 2) and receive-status (bank 1, offset 4) report the number of held bytes in bits 4:0.
- R4: A data write to a full transmit queue, a shifter byte into a full receive queue, a take from an empty transmit queue and a data read from an empty receive queue are all ignored. The counts saturate at 16 and 0.
- R5: Writing 1 to control-status (bank 1, offset 0) bit 6 empties both queues. It also clears the threshold and empty/full flags. Bit 6 always reads back 0, and both status registers then read 0.
- R6: The transmit threshold flag (transmit-status bit 6) sets when a shifter take leaves no more bytes than the threshold in transmit-control (bank 1, offset 1) bits 4:0. Writing 1 to that bit clears it.
- R7: The receive threshold flag (receive-status bit 6) sets when an accepted received byte brings the count to at least a non-zero threshold in receive-control (bank 1, offset 3) bits 4:0. Writing 1 to that bit clears it.
- R8: Control-status bit 1 sets when a take empties the transmit queue or a received byte fills the receive queue. Writing 1 to it clears it.
- R9: `irq` is high while the queues are enabled and any of the following holds:
  - transmit-control bit 6 is set together with the transmit threshold flag;
  - receive-control bit 6 is set together with the receive threshold flag;
  - control-status bit 3 is set together with the empty/full flag.
- R10: When receive-control bit 6 is set, `data_rdy` is high only when all 16 bytes are held. Otherwise `data_rdy` is high whenever at least one byte is held.
- R11: When receive-control is written with bit 5 set and a count N>0 in bits 4:0, `sh_nack` is high while exactly one of the N counted bytes remains, and low once the Nth byte has arrived.
- R12: While the enable bit is 0, data writes, data reads and shifter traffic leave both queues unchanged, and `irq` and `sh_tx_avail` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 1 | Register bank select from the controller |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset within the selected bank |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dat_wr | input | 1 | Software write of the data register |
| dat_wdata | input | 8 | Byte written to the data register |
| dat_rd | input | 1 | Software read of the data register |
| dat_rdata | output | 8 | Oldest received byte |
| sh_tx_take | input | 1 | Shift engine consumes one transmit byte |
| sh_tx_byte | output | 8 | Oldest transmit byte |
| sh_tx_avail | output | 1 | Transmit queue holds a byte |
| sh_rx_put | input | 1 | Shift engine delivers one received byte |
| sh_rx_byte | input | 8 | Received byte |
| sh_nack | output | 1 | NACK request for the byte now being received |
| data_rdy | output | 1 | Received data may be handed to software |
| irq | output | 1 | Interrupt request |

## Verification
The situation that is hardest to reach from the ports is the NACK window of the last-byte sequencer. It must rise exactly when one counted byte remains and fall as the final byte lands, and this timing has to hold for a count of one, which arms directly into the final state, as well as for longer counts. The stimulus drives the shift engine's receive strobe one byte at a time, samples `sh_nack` between strobes, and repeats after a queue clear with a count of one. Saturation on both queues is reached by pushing seventeen bytes and then taking past empty, with status reads between steps.

// File: rtl/smb_fifo_pkg.sv
package smb_fifo_pkg;

    // Register offsets within the window
    localparam logic [2:0] OFF_MODE = 3'd0;  // bank 0
    localparam logic [2:0] OFF_CS   = 3'd0;  // bank 1
    localparam logic [2:0] OFF_TXC  = 3'd1;
    localparam logic [2:0] OFF_TXS  = 3'd2;
    localparam logic [2:0] OFF_RXC  = 3'd3;
    localparam logic [2:0] OFF_RXS  = 3'd4;

    // Bit positions
    localparam int B_EN   = 4;
    localparam int B_CLR  = 6;
    localparam int B_IE   = 3;
    localparam int B_FLAG = 1;
    localparam int B_THIE = 6;
    localparam int B_LAST = 5;
    localparam int B_THST = 6;

    localparam int THR_W = 5;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_COUNT = 2'd1,
        SQ_FINAL = 2'd2,
        SQ_DONE  = 2'd3
    } sq_state_t;

endpackage

// File: rtl/smb_fifo_buf.sv
module smb_fifo_buf #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic          push_ok,
    output logic          pop_ok
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    assign push_ok = push && (cnt != CW'(DEPTH));
    assign pop_ok  = pop && (cnt != '0);
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/smb_fifo_rxseq.sv
module smb_fifo_rxseq
    import smb_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             arm,
    input  logic             arm_last,
    input  logic [THR_W-1:0] arm_thr,
    input  logic             rx_byte,
    output logic             nack
);
    sq_state_t        st, st_n;
    logic [THR_W-1:0] left, left_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= SQ_IDLE;
            left <= '0;
        end else begin
            st   <= st_n;
            left <= left_n;
        end
    end

    // Next state
    always_comb begin
        st_n   = st;
        left_n = left;
        if (clr) begin
            st_n   = SQ_IDLE;
            left_n = '0;
        end else if (arm) begin
            left_n = arm_thr;
            if (!arm_last || arm_thr == '0) st_n = SQ_IDLE;
            else if (arm_thr == THR_W'(1))  st_n = SQ_FINAL;
            else                            st_n = SQ_COUNT;
        end else begin
            unique case (st)
                SQ_IDLE: ;
                SQ_COUNT: if (rx_byte) begin
                    left_n = left - 1'b1;
                    if (left == THR_W'(2)) st_n = SQ_FINAL;
                end
                SQ_FINAL: if (rx_byte) begin
                    left_n = '0;
                    st_n   = SQ_DONE;
                end
                SQ_DONE: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        nack = (st == SQ_FINAL);
    end
endmodule

// File: rtl/smb_fifo_regs.sv
module smb_fifo_regs
    import smb_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_sel,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [CW-1:0]    tx_cnt,
    input  logic [CW-1:0]    rx_cnt,
    input  logic             tx_push_ok,
    input  logic             tx_pop_ok,
    input  logic             rx_push_ok,
    input  logic             rx_pop_ok,
    output logic             fifo_en,
    output logic             clr,
    output logic             rx_arm,
    output logic             rx_last,
    output logic [THR_W-1:0] rx_thr,
    output logic             irq,
    output logic             data_rdy
);
    logic             ie, flag, tx_thie, tx_thst, rx_thie, rx_thst;
    logic [THR_W-1:0] tx_thr;
    logic [CW:0]      tx_after, rx_after;
    logic             wr0, wr1, wr_mode, wr_cs, wr_txc, wr_txs, wr_rxc, wr_rxs;
    logic             tx_evt, rx_evt, flag_evt;

    assign wr0     = reg_wr && !bank_sel;
    assign wr1     = reg_wr && bank_sel;
    assign wr_mode = wr0 && (reg_addr == OFF_MODE);
    assign wr_cs   = wr1 && (reg_addr == OFF_CS);
    assign wr_txc  = wr1 && (reg_addr == OFF_TXC);
    assign wr_txs  = wr1 && (reg_addr == OFF_TXS);
    assign wr_rxc  = wr1 && (reg_addr == OFF_RXC);
    assign wr_rxs  = wr1 && (reg_addr == OFF_RXS);

    assign clr    = wr_cs && reg_wdata[B_CLR];
    assign rx_arm = wr_rxc;

    assign tx_after = {1'b0, tx_cnt} + (CW+1)'(tx_push_ok) - (CW+1)'(tx_pop_ok);
    assign rx_after = {1'b0, rx_cnt} + (CW+1)'(rx_push_ok) - (CW+1)'(rx_pop_ok);

    assign tx_evt   = tx_pop_ok && (8'(tx_after) <= 8'(tx_thr));
    assign rx_evt   = rx_push_ok && (rx_thr != '0) && (8'(rx_after) >= 8'(rx_thr));
    assign flag_evt = (tx_pop_ok && tx_after == '0) ||
                      (rx_push_ok && rx_after == (CW+1)'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            ie      <= 1'b0;
            flag    <= 1'b0;
            tx_thie <= 1'b0;
            tx_thr  <= '0;
            tx_thst <= 1'b0;
            rx_thie <= 1'b0;
            rx_last <= 1'b0;
            rx_thr  <= '0;
            rx_thst <= 1'b0;
        end else begin
            if (wr_mode) fifo_en <= reg_wdata[B_EN];
            if (wr_cs)   ie <= reg_wdata[B_IE];
            if (wr_txc) begin
                tx_thie <= reg_wdata[B_THIE];
                tx_thr  <= reg_wdata[THR_W-1:0];
            end
            if (wr_rxc) begin
                rx_thie <= reg_wdata[B_THIE];
                rx_last <= reg_wdata[B_LAST];
                rx_thr  <= reg_wdata[THR_W-1:0];
            end
            if (clr) begin
                flag    <= 1'b0;
                tx_thst <= 1'b0;
                rx_thst <= 1'b0;
            end else begin
                flag    <= flag_evt || (flag && !(wr_cs && reg_wdata[B_FLAG]));
                tx_thst <= tx_evt || (tx_thst && !(wr_txs && reg_wdata[B_THST]));
                rx_thst <= rx_evt || (rx_thst && !(wr_rxs && reg_wdata[B_THST]));
            end
        end
    end

    assign irq = fifo_en && ((tx_thie && tx_thst) || (rx_thie && rx_thst) || (ie && flag));
    assign data_rdy = fifo_en && (rx_thie ? (rx_cnt == CW'(DEPTH)) : (rx_cnt != '0));

    always_comb begin
        reg_rdata = 8'h00;
        if (!bank_sel) begin
            if (reg_addr == OFF_MODE) reg_rdata[B_EN] = fifo_en;
        end else begin
            case (reg_addr)
                OFF_CS: begin
                    reg_rdata[B_IE]   = ie;
                    reg_rdata[B_FLAG] = flag;
                end
                OFF_TXC: begin
                    reg_rdata[B_THIE]      = tx_thie;
                    reg_rdata[THR_W-1:0]   = tx_thr;
                end
                OFF_TXS: begin
                    reg_rdata[B_THST]      = tx_thst;
                    reg_rdata[THR_W-1:0]   = THR_W'(tx_cnt);
                end
                OFF_RXC: begin
                    reg_rdata[B_THIE]      = rx_thie;
                    reg_rdata[B_LAST]      = rx_last;
                    reg_rdata[THR_W-1:0]   = rx_thr;
                end
                OFF_RXS: begin
                    reg_rdata[B_THST]      = rx_thst;
                    reg_rdata[THR_W-1:0]   = THR_W'(rx_cnt);
                end
                default: reg_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/smb_xfer_fifo.sv
module smb_xfer_fifo
    import smb_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bank_sel,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          dat_wr,
    input  logic [DW-1:0] dat_wdata,
    input  logic          dat_rd,
    output logic [DW-1:0] dat_rdata,
    input  logic          sh_tx_take,
    output logic [DW-1:0] sh_tx_byte,
    output logic          sh_tx_avail,
    input  logic          sh_rx_put,
    input  logic [DW-1:0] sh_rx_byte,
    output logic          sh_nack,
    output logic          data_rdy,
    output logic          irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             fifo_en, clr, rx_arm, rx_last;
    logic [THR_W-1:0] rx_thr;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic             tx_push, tx_pop, rx_push, rx_pop;

    assign tx_push = dat_wr && fifo_en;
    assign tx_pop  = sh_tx_take && fifo_en;
    assign rx_push = sh_rx_put && fifo_en;
    assign rx_pop  = dat_rd && fifo_en;

    assign sh_tx_avail = fifo_en && (tx_cnt != '0);

    smb_fifo_buf #(.W(DW), .DEPTH(DEPTH), .CW(CW)) i_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(tx_push), .din(dat_wdata), .pop(tx_pop), .dout(sh_tx_byte),
        .cnt(tx_cnt), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    smb_fifo_buf #(.W(DW), .DEPTH(DEPTH), .CW(CW)) i_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(rx_push), .din(sh_rx_byte), .pop(rx_pop), .dout(dat_rdata),
        .cnt(rx_cnt), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    smb_fifo_regs #(.DEPTH(DEPTH), .CW(CW)) i_regs (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_push_ok(tx_push_ok), .tx_pop_ok(tx_pop_ok),
        .rx_push_ok(rx_push_ok), .rx_pop_ok(rx_pop_ok),
        .fifo_en(fifo_en), .clr(clr), .rx_arm(rx_arm), .rx_last(rx_last),
        .rx_thr(rx_thr), .irq(irq), .data_rdy(data_rdy)
    );

    smb_fifo_rxseq i_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .arm(rx_arm),
        .arm_last(reg_wdata[B_LAST]), .arm_thr(reg_wdata[THR_W-1:0]),
        .rx_byte(rx_push), .nack(sh_nack)
    );
endmodule

// File: rtl/smb_fifo_chk.sv
module smb_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          clr,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          sh_tx_take,
    input logic          sh_tx_avail,
    input logic          sh_nack,
    input logic          rx_last,
    input logic          irq
);
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == CW'(DEPTH) && !sh_tx_take && !clr) |=> (tx_cnt == CW'(DEPTH)));

    p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tx_cnt == '0 && rx_cnt == '0));

    p_avail_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_tx_avail |-> (tx_cnt != '0));

    p_nack_armed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sh_nack |-> rx_last);

    p_quiet_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (!irq && !sh_tx_avail));

    p_off_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !clr) |=> ($stable(tx_cnt) && $stable(rx_cnt)));
endmodule

bind smb_xfer_fifo smb_fifo_chk #(.DEPTH(DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .clr(clr),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .sh_tx_take(sh_tx_take),
    .sh_tx_avail(sh_tx_avail), .sh_nack(sh_nack), .rx_last(rx_last), .irq(irq)
);

// File: tb/test_smb_xfer_fifo.sv
`timescale 1ns/1ps
module test_smb_xfer_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_sel = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       dat_wr = 1'b0, dat_rd = 1'b0;
    logic [7:0] dat_wdata = '0, dat_rdata;
    logic       sh_tx_take = 1'b0, sh_tx_avail;
    logic [7:0] sh_tx_byte;
    logic       sh_rx_put = 1'b0;
    logic [7:0] sh_rx_byte = '0;
    logic       sh_nack, data_rdy, irq;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    smb_xfer_fifo i_smb_xfer_fifo (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
        .sh_tx_take(sh_tx_take), .sh_tx_byte(sh_tx_byte), .sh_tx_avail(sh_tx_avail),
        .sh_rx_put(sh_rx_put), .sh_rx_byte(sh_rx_byte), .sh_nack(sh_nack),
        .data_rdy(data_rdy), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic b, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bank_sel = b; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic b, input logic [2:0] a, output logic [7:0] v);
        bank_sel = b; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); dat_wdata = d; dat_wr = 1'b1;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic take();
        @(negedge clk); sh_tx_take = 1'b1;
        @(negedge clk); sh_tx_take = 1'b0;
    endtask

    task automatic rxput(input logic [7:0] d);
        @(negedge clk); sh_rx_byte = d; sh_rx_put = 1'b1;
        @(negedge clk); sh_rx_put = 1'b0;
    endtask

    task automatic dread(output logic [7:0] v);
        @(negedge clk); dat_rd = 1'b1;
        #1 v = dat_rdata;
        @(negedge clk); dat_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rreg(0, 3'd0, v); chk("R1 mode reg", v, 8'h00);
        for (int a = 0; a < 5; a++) begin
            rreg(1, 3'(a), v); chk("R1 bank1 reg", v, 8'h00);
        end
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 data_rdy", {7'd0, data_rdy}, 8'h00);
        chk("R1 nack", {7'd0, sh_nack}, 8'h00);
        chk("R1 avail", {7'd0, sh_tx_avail}, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        push(8'hAA);
        rxput(8'hBB);
        take();
        rreg(1, 3'd2, v); chk("R12 tx count while off", v, 8'h00);
        rreg(1, 3'd4, v); chk("R12 rx count while off", v, 8'h00);
        chk("R12 avail while off", {7'd0, sh_tx_avail}, 8'h00);
        chk("R12 irq while off", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_bank();
        logic [7:0] v;
        wreg(0, 3'd0, 8'h10);
        rreg(0, 3'd0, v); chk("R2 enable bank0", v, 8'h10);
        wreg(1, 3'd0, 8'h08);
        rreg(0, 3'd0, v); chk("R2 bank0 kept", v, 8'h10);
        rreg(1, 3'd0, v); chk("R2 bank1 ctl-status", v, 8'h08);
        wreg(1, 3'd0, 8'h00);
        rreg(1, 3'd0, v); chk("R2 bank1 cleared", v, 8'h00);
    endtask

    task automatic t_tx();
        logic [7:0] v;
        wreg(1, 3'd1, 8'h40);
        push(8'h11); push(8'h22); push(8'h33);
        rreg(1, 3'd2, v); chk("R3 tx count 3", v, 8'h03);
        chk("R3 avail", {7'd0, sh_tx_avail}, 8'h01);
        chk("R3 tx byte0", sh_tx_byte, 8'h11);
        take(); chk("R3 tx byte1", sh_tx_byte, 8'h22);
        take(); chk("R3 tx byte2", sh_tx_byte, 8'h33);
        rreg(1, 3'd2, v); chk("R6 no thst at 1", v, 8'h01);
        take();
        rreg(1, 3'd2, v); chk("R6 thst on drain", v, 8'h40);
        rreg(1, 3'd0, v); chk("R8 flag on drain", v, 8'h02);
        chk("R9 irq from tx thr", {7'd0, irq}, 8'h01);
        wreg(1, 3'd2, 8'h40);
        rreg(1, 3'd2, v); chk("R6 thst w1c", v, 8'h00);
        chk("R9 irq off", {7'd0, irq}, 8'h00);
        wreg(1, 3'd0, 8'h08);
        chk("R9 irq from flag", {7'd0, irq}, 8'h01);
        wreg(1, 3'd0, 8'h0A);
        rreg(1, 3'd0, v); chk("R8 flag w1c", v, 8'h08);
        chk("R9 irq flag cleared", {7'd0, irq}, 8'h00);
        wreg(1, 3'd0, 8'h00);
    endtask

    task automatic t_saturate();
        logic [7:0] v;
        for (int i = 0; i < 17; i++) push(8'(8'h80 + i));
        rreg(1, 3'd2, v); chk("R4 tx count saturates", v, 8'h10);
        for (int i = 0; i < 16; i++) begin
            #1 chk("R4 tx order after overflow", sh_tx_byte, 8'(8'h80 + i));
            take();
        end
        take();
        rreg(1, 3'd2, v); chk("R4 tx empty take ignored", v, 8'h40);
        chk("R4 avail empty", {7'd0, sh_tx_avail}, 8'h00);
        wreg(1, 3'd2, 8'h40);
        wreg(1, 3'd0, 8'h02);
        wreg(1, 3'd3, 8'h40);
        for (int i = 0; i < 15; i++) rxput(8'(i));
        chk("R10 not ready below 16", {7'd0, data_rdy}, 8'h00);
        rxput(8'h0F); rxput(8'hEE);
        rreg(1, 3'd4, v); chk("R4 rx count saturates", v, 8'h10);
        chk("R10 ready at 16", {7'd0, data_rdy}, 8'h01);
        rreg(1, 3'd0, v); chk("R8 flag on rx full", v, 8'h02);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        push(8'h01); push(8'h02);
        wreg(1, 3'd0, 8'h40);
        rreg(1, 3'd0, v); chk("R5 clr reads 0", v, 8'h00);
        rreg(1, 3'd2, v); chk("R5 tx status 0", v, 8'h00);
        rreg(1, 3'd4, v); chk("R5 rx status 0", v, 8'h00);
        chk("R5 avail 0", {7'd0, sh_tx_avail}, 8'h00);
        dread(v);
        rreg(1, 3'd4, v); chk("R4 rx empty read ignored", v, 8'h00);
    endtask

    task automatic t_rxthr();
        logic [7:0] v;
        wreg(1, 3'd3, 8'h43);
        rxput(8'h5A); rxput(8'h5B);
        rreg(1, 3'd4, v); chk("R7 below thr", v, 8'h02);
        chk("R10 gated low", {7'd0, data_rdy}, 8'h00);
        rxput(8'h5C);
        rreg(1, 3'd4, v); chk("R7 thst at thr", v, 8'h43);
        chk("R9 irq from rx thr", {7'd0, irq}, 8'h01);
        wreg(1, 3'd3, 8'h03);
        chk("R10 ready ungated", {7'd0, data_rdy}, 8'h01);
        chk("R9 irq rx ie off", {7'd0, irq}, 8'h00);
        dread(v); chk("R3 rx byte0", v, 8'h5A);
        dread(v); chk("R3 rx byte1", v, 8'h5B);
        dread(v); chk("R3 rx byte2", v, 8'h5C);
        rreg(1, 3'd4, v); chk("R3 rx drained", v, 8'h40);
        chk("R10 empty not ready", {7'd0, data_rdy}, 8'h00);
        wreg(1, 3'd4, 8'h40);
        rreg(1, 3'd4, v); chk("R7 thst w1c", v, 8'h00);
    endtask

    task automatic t_last();
        logic [7:0] v;
        wreg(1, 3'd3, 8'h63);
        chk("R11 no nack first", {7'd0, sh_nack}, 8'h00);
        rxput(8'h01);
        chk("R11 no nack second", {7'd0, sh_nack}, 8'h00);
        rxput(8'h02);
        chk("R11 nack on final", {7'd0, sh_nack}, 8'h01);
        rxput(8'h03);
        chk("R11 nack drops after final", {7'd0, sh_nack}, 8'h00);
        rreg(1, 3'd4, v); chk("R7 count 3 thst", v, 8'h43);
        wreg(1, 3'd0, 8'h40);
        wreg(1, 3'd3, 8'h61);
        chk("R11 single byte nack", {7'd0, sh_nack}, 8'h01);
        rxput(8'h77);
        chk("R11 single byte done", {7'd0, sh_nack}, 8'h00);
        rreg(1, 3'd4, v); chk("R7 one byte thst", v, 8'h41);
        dread(v); chk("R3 single byte data", v, 8'h77);
        rreg(1, 3'd4, v); chk("R3 count back to 0", v, 8'h40);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_bank();
        t_tx();
        t_saturate();
        t_clear();
        t_rxthr();
        t_last();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule